// File: doc/BRIEF.md
# Ternary Match Table Command Controller

This block holds a small ternary match table of 43 entries, each with a 100-bit key and a 100-bit care mask, and beside it a 43-entry result memory whose words carry one parity bit. Software reaches both through a narrow register write port. It loads key and mask holding registers, each split into a 64-bit low part and a 36-bit high part. It then writes a command word that holds an opcode, a target index and a status bit. Writing the status bit as 0 starts the operation, and the bit reads 1 again once the operation is finished.

Four operations exist. Entry write copies the holding registers into the table. Compare searches the table with the key holding register and reports a hit flag and the winning index. Result write stores the low key register into the result memory. Result read loads a result word back into the low key register. Reads check parity. On a mismatch the block raises a sticky flag and records the failing index until software clears the flag.

A separate bulk-clear trigger zeroes every table entry, one entry per cycle. A lookup-enable output tells an external classification pipeline when the table may be searched, and that output is low for the whole clear.

Top module: `tcam_cmd_ctrl`

## Requirements
- R1: After reset the status bit reads 1, the hit flag, the parity flag and the parity log read 0, and both the clear-done and lookup-enable outputs read 1.
- R2: Opcodes 3'b001, 3'b011, 3'b110 and 3'b111 are reserved. Such a command completes like any other and sets the hit flag to 0. It leaves the low key register and the table unchanged, and the index field keeps the written index.
- R3: A command word written with bit 11 = 0 while no command is running makes the status output read 0 in the next cycle and 1 in the cycle after that. A command word written with bit 11 = 1 starts nothing.
- R4: Compare (opcode 3'b010) sets the hit flag to 1 and the index field to the lowest matching entry number when any entry matches. With no match it sets the hit flag to 0 and the index field keeps the written index.
- R5: An entry matches when its stored key equals the compare key at every one of the 100 bit positions whose stored mask bit is 1. Positions whose mask bit is 0 are ignored. The upper 36 bits take part in the same way as the lower 64.
- R6: Entry write (opcode 3'b000) stores the key {high,low} and the mask {high,low} at the given index. An index above 42 changes no entry.
- R7: Result write (opcode 3'b100) stores the low key register at the given index. Result read (opcode 3'b101) loads the stored word into the low key register. A read from an index above 42 loads 0, and a write to such an index is dropped.
- R8: A result write normally stores the even parity bit, which is the XOR of the 64 data bits. With command bit 12 set, it stores bit 0 of the high key register instead. A read whose stored parity differs from the XOR of its data sets the parity flag and records the index, but only if the flag is clear; the first log is kept. Writing 1 to bit 0 of select 5 clears both the flag and the log.
- R9: Any write to select 6 clears every entry's key and mask to zero, so afterwards every compare hits entry 0. Clear-done reads 0 for the 43 cycles after the write and then reads 1.
- R10: While the bulk clear runs, lookup-enable reads 0 and command starts are ignored. The status stays 1 and the index field keeps its value.
- R11: Register selects are 0 low key, 1 high key (36 bits), 2 low mask, 3 high mask, 4 command, 5 parity flag clear, and 6 bulk clear. The command word holds the index in bits [7:0], the opcode in bits [10:8], the status in bit 11 and the parity override in bit 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 64 | Register write data |
| key_lo_q | output | 64 | Low key register, also the result data path |
| cmd_status | output | 1 | 1 when idle/finished, 0 while a command is pending |
| cmd_match | output | 1 | Hit flag of the last compare |
| cmd_addr | output | 8 | Index field: written index or hit index |
| par_irq | output | 1 | Sticky result parity error flag |
| par_log | output | 8 | Index of the first parity error |
| init_done | output | 1 | 0 while the bulk clear runs |
| lookup_en | output | 1 | Table may be searched by the external pipeline |

## Verification
The assertions assume that software starts no new command and no bulk clear in the single cycle while a command executes, and that the table has been bulk-cleared once before any compare, because table storage has no reset. The stimulus waits for the status bit after every command and runs a bulk clear before any other table access. The reserved, out-of-range and overlapping-hit cases are covered by a vector table, and the parity and clear paths are covered by directed sequences that keep to the same ordering.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  typedef enum logic [2:0] {
    OP_TWR  = 3'b000,
    OP_RS1  = 3'b001,
    OP_CMP  = 3'b010,
    OP_RS3  = 3'b011,
    OP_RWR  = 3'b100,
    OP_RRD  = 3'b101,
    OP_RS6  = 3'b110,
    OP_RS7  = 3'b111
  } op_e;

  localparam logic [2:0] SEL_KLO  = 3'd0;
  localparam logic [2:0] SEL_KHI  = 3'd1;
  localparam logic [2:0] SEL_MLO  = 3'd2;
  localparam logic [2:0] SEL_MHI  = 3'd3;
  localparam logic [2:0] SEL_CMD  = 3'd4;
  localparam logic [2:0] SEL_ICLR = 3'd5;
  localparam logic [2:0] SEL_INIT = 3'd6;

  localparam int OP_LSB   = 8;
  localparam int STAT_BIT = 11;
  localparam int PDBG_BIT = 12;

  function automatic logic op_reserved(input op_e op);
    return !(op inside {OP_TWR, OP_CMP, OP_RWR, OP_RRD});
  endfunction

endpackage

// File: rtl/tcam_array.sv
module tcam_array #(
  parameter int N_ENTRIES = 43,
  parameter int KEY_W     = 100,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [KEY_W-1:0] wr_key,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [KEY_W-1:0] cmp_key,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);

  logic [KEY_W-1:0]     key_mem  [N_ENTRIES];
  logic [KEY_W-1:0]     mask_mem [N_ENTRIES];
  logic [N_ENTRIES-1:0] hit_vec;

  // storage: no reset, filled by the bulk clear
  always_ff @(posedge clk) begin
    if (wr_en) begin
      key_mem[wr_idx]  <= wr_key;
      mask_mem[wr_idx] <= wr_mask;
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = ~|((key_mem[g] ^ cmp_key) & mask_mem[g]);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit = |hit_vec;

  // R4: reported index is a hitting entry with no lower hitting entry
  a_r4_lowest_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hit_vec[hit_idx] &&
             ((hit_vec & ~({N_ENTRIES{1'b1}} << hit_idx)) == '0)));

endmodule

// File: rtl/result_ram.sv
module result_ram #(
  parameter int N_ENTRIES = 43,
  parameter int DATA_W    = 64,
  parameter int IDX_W     = $clog2(N_ENTRIES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              dbg_par_en,
  input  logic              dbg_par,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_par_err
);

  logic [DATA_W-1:0] data_mem [N_ENTRIES];
  logic              par_mem  [N_ENTRIES];
  logic              par_gen;

  assign par_gen = dbg_par_en ? dbg_par : ^wr_data;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      data_mem[wr_idx] <= wr_data;
      par_mem[wr_idx]  <= par_gen;
    end
  end

  assign rd_data    = data_mem[rd_idx];
  assign rd_par_err = par_mem[rd_idx] ^ (^rd_data);

endmodule

// File: rtl/tcam_cmd_ctrl.sv
module tcam_cmd_ctrl
  import tcam_pkg::*;
#(
  parameter int N_ENTRIES = 43,
  parameter int KEY_W     = 100,
  parameter int LO_W      = 64,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_sel,
  input  logic [LO_W-1:0]   reg_wdata,
  output logic [LO_W-1:0]   key_lo_q,
  output logic              cmd_status,
  output logic              cmd_match,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              par_irq,
  output logic [ADDR_W-1:0] par_log,
  output logic              init_done,
  output logic              lookup_en
);

  localparam int HI_W  = KEY_W - LO_W;
  localparam int IDX_W = $clog2(N_ENTRIES);
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(N_ENTRIES - 1);
  localparam logic [ADDR_W-1:0] ADDR_LIM  = ADDR_W'(N_ENTRIES);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  // holding registers (datapath, no reset)
  logic [HI_W-1:0] key_hi_q, mask_hi_q;
  logic [LO_W-1:0] mask_lo_q;
  logic [LO_W-1:0] key_lo_n;
  logic            key_lo_en, key_hi_en, mask_lo_en, mask_hi_en;

  // control state
  op_e               op_q, op_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic              pdbg_q, pdbg_n;
  logic              busy_q, busy_n;
  logic              done_q, done_n;
  logic              match_q, match_n;
  logic              irq_q, irq_n;
  logic [ADDR_W-1:0] log_q, log_n;
  logic              ibusy_q, ibusy_n;
  logic [IDX_W-1:0]  icnt_q, icnt_n;

  // decode
  logic wr_cmd, start_acc, irq_clr, init_trig;
  logic in_range;
  logic ex_twr, ex_cmp, ex_rwr, ex_rrd, ex_rsv;
  logic [IDX_W-1:0] idx_q;

  assign wr_cmd    = reg_wr && (reg_sel == SEL_CMD);
  assign start_acc = wr_cmd && !reg_wdata[STAT_BIT] && !busy_q && !ibusy_q;
  assign irq_clr   = reg_wr && (reg_sel == SEL_ICLR) && reg_wdata[0];
  assign init_trig = reg_wr && (reg_sel == SEL_INIT);

  assign in_range = (addr_q < ADDR_LIM);
  assign idx_q    = addr_q[IDX_W-1:0];
  assign ex_twr   = busy_q && (op_q == OP_TWR);
  assign ex_cmp   = busy_q && (op_q == OP_CMP);
  assign ex_rwr   = busy_q && (op_q == OP_RWR);
  assign ex_rrd   = busy_q && (op_q == OP_RRD);
  assign ex_rsv   = busy_q && op_reserved(op_q);

  // table
  logic             arr_wr;
  logic [IDX_W-1:0] arr_idx;
  logic [KEY_W-1:0] arr_key, arr_mask, cmp_key;
  logic             hit;
  logic [IDX_W-1:0] hit_idx;

  assign arr_wr   = ibusy_q || (ex_twr && in_range);
  assign arr_idx  = ibusy_q ? icnt_q : idx_q;
  assign arr_key  = ibusy_q ? '0 : {key_hi_q, key_lo_q};
  assign arr_mask = ibusy_q ? '0 : {mask_hi_q, mask_lo_q};
  assign cmp_key  = {key_hi_q, key_lo_q};

  tcam_array #(
    .N_ENTRIES (N_ENTRIES),
    .KEY_W     (KEY_W),
    .IDX_W     (IDX_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_ni),
    .wr_en   (arr_wr),
    .wr_idx  (arr_idx),
    .wr_key  (arr_key),
    .wr_mask (arr_mask),
    .cmp_key (cmp_key),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  // result memory
  logic [LO_W-1:0] ram_rd;
  logic            ram_perr;

  result_ram #(
    .N_ENTRIES (N_ENTRIES),
    .DATA_W    (LO_W),
    .IDX_W     (IDX_W)
  ) u_ram (
    .clk        (clk),
    .wr_en      (ex_rwr && in_range),
    .wr_idx     (idx_q),
    .wr_data    (key_lo_q),
    .dbg_par_en (pdbg_q),
    .dbg_par    (key_hi_q[0]),
    .rd_idx     (idx_q),
    .rd_data    (ram_rd),
    .rd_par_err (ram_perr)
  );

  // holding register next state and enables
  assign key_hi_en  = reg_wr && (reg_sel == SEL_KHI);
  assign mask_lo_en = reg_wr && (reg_sel == SEL_MLO);
  assign mask_hi_en = reg_wr && (reg_sel == SEL_MHI);
  assign key_lo_en  = (reg_wr && (reg_sel == SEL_KLO)) || ex_rrd;

  always_comb begin
    key_lo_n = reg_wdata;
    if (ex_rrd) key_lo_n = in_range ? ram_rd : '0;
  end

  always_ff @(posedge clk) begin
    if (key_lo_en)  key_lo_q  <= key_lo_n;
    if (key_hi_en)  key_hi_q  <= reg_wdata[HI_W-1:0];
    if (mask_lo_en) mask_lo_q <= reg_wdata;
    if (mask_hi_en) mask_hi_q <= reg_wdata[HI_W-1:0];
  end

  // command sequencing next state
  always_comb begin
    op_n    = op_q;
    addr_n  = addr_q;
    pdbg_n  = pdbg_q;
    busy_n  = busy_q;
    done_n  = done_q;
    match_n = match_q;
    if (start_acc) begin
      op_n   = op_e'(reg_wdata[OP_LSB +: 3]);
      addr_n = reg_wdata[ADDR_W-1:0];
      pdbg_n = reg_wdata[PDBG_BIT];
      busy_n = 1'b1;
      done_n = 1'b0;
    end else if (busy_q) begin
      busy_n = 1'b0;
      done_n = 1'b1;
      if (ex_cmp) begin
        match_n = hit;
        if (hit) addr_n = {{(ADDR_W-IDX_W){1'b0}}, hit_idx};
      end else if (ex_rsv) begin
        match_n = 1'b0;
      end
    end
  end

  // parity flag and log next state
  always_comb begin
    irq_n = irq_q;
    log_n = log_q;
    if (irq_clr) begin
      irq_n = 1'b0;
      log_n = '0;
    end else if (ex_rrd && in_range && ram_perr && !irq_q) begin
      irq_n = 1'b1;
      log_n = addr_q;
    end
  end

  // bulk clear next state
  always_comb begin
    ibusy_n = ibusy_q;
    icnt_n  = icnt_q;
    if (init_trig) begin
      ibusy_n = 1'b1;
      icnt_n  = '0;
    end else if (ibusy_q) begin
      if (icnt_q == LAST_IDX) ibusy_n = 1'b0;
      else                    icnt_n  = icnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q    <= OP_TWR;
      addr_q  <= '0;
      pdbg_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b1;
      match_q <= 1'b0;
      irq_q   <= 1'b0;
      log_q   <= '0;
      ibusy_q <= 1'b0;
      icnt_q  <= '0;
    end else begin
      op_q    <= op_n;
      addr_q  <= addr_n;
      pdbg_q  <= pdbg_n;
      busy_q  <= busy_n;
      done_q  <= done_n;
      match_q <= match_n;
      irq_q   <= irq_n;
      log_q   <= log_n;
      ibusy_q <= ibusy_n;
      icnt_q  <= icnt_n;
    end
  end

  assign cmd_status = done_q;
  assign cmd_match  = match_q;
  assign cmd_addr   = addr_q;
  assign par_irq    = irq_q;
  assign par_log    = log_q;
  assign init_done  = !ibusy_q;
  assign lookup_en  = rst_ni && !ibusy_q;

  // R3: an accepted start drops the status, execution raises it again
  a_r3_start_drops_status: assert property (@(posedge clk) disable iff (!rst_ni)
    start_acc |=> !cmd_status);
  a_r3_one_cycle_exec: assert property (@(posedge clk) disable iff (!rst_ni)
    busy_q |=> (cmd_status && !busy_q));

  // R4: a hitting compare reports the encoder's index
  a_r4_hit_reported: assert property (@(posedge clk) disable iff (!rst_ni)
    (ex_cmp && hit && !start_acc) |=> (cmd_match && cmd_addr == ADDR_W'($past(hit_idx))));

  // R2: reserved opcodes leave the hit flag low
  a_r2_reserved_clears: assert property (@(posedge clk) disable iff (!rst_ni)
    (ex_rsv && !start_acc) |=> !cmd_match);

  // R8: a raised flag and its log hold until cleared
  a_r8_log_held: assert property (@(posedge clk) disable iff (!rst_ni)
    (par_irq && !irq_clr) |=> (par_irq && $stable(par_log)));

  // R9: a clear trigger takes lookups away in the next cycle
  a_r9_init_blocks_lookup: assert property (@(posedge clk) disable iff (!rst_ni)
    init_trig |=> (!lookup_en && !init_done));

endmodule

// File: tb/tcam_cmd_ctrl_test.sv
module tcam_cmd_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] F64 = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam logic [35:0] F36 = 36'hF_FFFF_FFFF;
  localparam logic [63:0] M4  = 64'hFFFF_FFFF_FFFF_FFF0;
  localparam logic [2:0] TWR = 3'b000, CMP = 3'b010, RWR = 3'b100,
                         RRD = 3'b101, RSV = 3'b011;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  addr;
    logic [63:0] klo;
    logic [35:0] khi;
    logic [63:0] mlo;
    logic [35:0] mhi;
    logic        em;
    logic [7:0]  ea;
    logic [63:0] ek;
  } vec_t;

  // entries 0..42 hold key 1000+i with full care mask before this table
  localparam vec_t VECS [16] = '{
    '{TWR, 8'd12, 64'h77,  36'h0, M4,  F36, 1'b0, 8'd0,  64'h0},  // R6 low nibble ignored
    '{CMP, 8'd0,  64'h7A,  36'h0, 64'h0, 36'h0, 1'b1, 8'd12, 64'h0}, // R5 don't-care hit
    '{CMP, 8'd0,  64'h3FB, 36'h0, 64'h0, 36'h0, 1'b1, 8'd19, 64'h0},
    '{TWR, 8'd3,  64'h3FB, 36'h0, F64, F36, 1'b0, 8'd0,  64'h0},
    '{CMP, 8'd0,  64'h3FB, 36'h0, 64'h0, 36'h0, 1'b1, 8'd3,  64'h0}, // lowest wins
    '{CMP, 8'd9,  64'h5,   36'h0, 64'h0, 36'h0, 1'b0, 8'd9,  64'h0}, // miss
    '{CMP, 8'd9,  64'h3FB, 36'h1, 64'h0, 36'h0, 1'b0, 8'd9,  64'h0}, // R5 high bits
    '{TWR, 8'd43, 64'h55,  36'h0, F64, F36, 1'b0, 8'd0,  64'h0},  // out of range
    '{CMP, 8'd2,  64'h55,  36'h0, 64'h0, 36'h0, 1'b0, 8'd2,  64'h0},
    '{RWR, 8'd4,  64'hDEAD_BEEF_0123_4567, 36'h0, 64'h0, 36'h0, 1'b0, 8'd0, 64'h0},
    '{RWR, 8'd42, 64'h1,   36'h0, 64'h0, 36'h0, 1'b0, 8'd0,  64'h0},
    '{RRD, 8'd4,  64'h0,   36'h0, 64'h0, 36'h0, 1'b0, 8'd0,  64'hDEAD_BEEF_0123_4567},
    '{RRD, 8'd42, 64'h0,   36'h0, 64'h0, 36'h0, 1'b0, 8'd0,  64'h1},
    '{CMP, 8'd0,  64'h3E8, 36'h0, 64'h0, 36'h0, 1'b1, 8'd0,  64'h0},
    '{RRD, 8'd60, 64'hAAAA, 36'h0, 64'h0, 36'h0, 1'b0, 8'd0, 64'h0},
    '{RSV, 8'd1,  64'h99,  36'h0, 64'h0, 36'h0, 1'b0, 8'd1,  64'h99}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] key_lo_q;
  logic        cmd_status, cmd_match, par_irq, init_done, lookup_en;
  logic [7:0]  cmd_addr, par_log;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcam_cmd_ctrl uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .reg_wdata  (reg_wdata),
    .key_lo_q   (key_lo_q),
    .cmd_status (cmd_status),
    .cmd_match  (cmd_match),
    .cmd_addr   (cmd_addr),
    .par_irq    (par_irq),
    .par_log    (par_log),
    .init_done  (init_done),
    .lookup_en  (lookup_en)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  function automatic logic [63:0] cw(input logic [2:0] op, input logic [7:0] a, input logic dbg);
    return {51'b0, dbg, 1'b0, op, a};
  endfunction

  task automatic run_cmd(input logic [2:0] op, input logic [7:0] a, input logic dbg);
    wr(3'd4, cw(op, a, dbg));
    chk(cmd_status == 1'b0, "R3 status low after start", 64'(cmd_status), 64'd0);
    @(negedge clk);
    chk(cmd_status == 1'b1, "R3 status high on completion", 64'(cmd_status), 64'd1);
  endtask

  task automatic load(input logic [63:0] klo, input logic [35:0] khi,
                      input logic [63:0] mlo, input logic [35:0] mhi);
    wr(3'd0, klo);
    wr(3'd1, 64'(khi));
    wr(3'd2, mlo);
    wr(3'd3, 64'(mhi));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R3 watchdog expired actual=0 expected=1");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(cmd_status == 1'b1, "R1 status", 64'(cmd_status), 64'd1);
    chk(cmd_match == 1'b0, "R1 match", 64'(cmd_match), 64'd0);
    chk(par_irq == 1'b0, "R1 parity flag", 64'(par_irq), 64'd0);
    chk(par_log == 8'd0, "R1 parity log", 64'(par_log), 64'd0);
    chk(init_done && lookup_en, "R1 init_done/lookup_en", 64'({init_done, lookup_en}), 64'd3);

    // R9 bulk clear timing, R10 lookup suspended
    wr(3'd6, 64'd0);
    chk(init_done == 1'b0, "R9 clear busy at start", 64'(init_done), 64'd0);
    for (int k = 1; k <= 42; k++) begin
      @(negedge clk);
      if (!(init_done == 1'b0 && lookup_en == 1'b0))
        chk(1'b0, "R10 lookup off during clear", 64'({init_done, lookup_en}), 64'd0);
    end
    chk(lookup_en == 1'b0, "R10 lookup off late in clear", 64'(lookup_en), 64'd0);
    @(negedge clk);
    chk(init_done == 1'b1, "R9 clear done after 43 cycles", 64'(init_done), 64'd1);
    chk(lookup_en == 1'b1, "R10 lookup back on", 64'(lookup_en), 64'd1);

    // R9 all-zero entries: any key hits entry 0
    load(64'h1234_5678, 36'h5, 64'h0, 36'h0);
    run_cmd(CMP, 8'd30, 1'b0);
    chk(cmd_match && cmd_addr == 8'd0, "R9 cleared table hits entry 0", 64'({cmd_match, cmd_addr}), 64'h100);

    // program every entry with key 1000+i, full care mask (R6, R11)
    for (int i = 0; i < 43; i++) begin
      load(64'(1000 + i), 36'h0, F64, F36);
      run_cmd(TWR, 8'(i), 1'b0);
    end

    // vector walk
    for (int v = 0; v < 16; v++) begin
      load(VECS[v].klo, VECS[v].khi, VECS[v].mlo, VECS[v].mhi);
      run_cmd(VECS[v].op, VECS[v].addr, 1'b0);
      case (VECS[v].op)
        CMP: begin
          chk(cmd_match == VECS[v].em, "R4 compare hit flag", 64'(cmd_match), 64'(VECS[v].em));
          chk(cmd_addr == VECS[v].ea, "R4 compare index", 64'(cmd_addr), 64'(VECS[v].ea));
        end
        RRD: chk(key_lo_q == VECS[v].ek, "R7 result read data", key_lo_q, VECS[v].ek);
        RSV: begin
          chk(cmd_match == 1'b0, "R2 reserved clears match", 64'(cmd_match), 64'd0);
          chk(key_lo_q == VECS[v].ek, "R2 reserved keeps key", key_lo_q, VECS[v].ek);
          chk(cmd_addr == VECS[v].ea, "R2 reserved index", 64'(cmd_addr), 64'(VECS[v].ea));
        end
        default: ;
      endcase
    end

    // R3 status bit written as 1 starts nothing
    wr(3'd4, cw(CMP, 8'd7, 1'b0) | 64'h800);
    chk(cmd_status == 1'b1 && cmd_addr == 8'd1, "R3 no start with status 1",
        64'({cmd_status, cmd_addr}), 64'h101);

    // R8 parity override and log
    load(64'h3, 36'h1, 64'h0, 36'h0);
    run_cmd(RWR, 8'd6, 1'b1);
    run_cmd(RRD, 8'd6, 1'b0);
    chk(par_irq == 1'b1, "R8 parity flag set", 64'(par_irq), 64'd1);
    chk(par_log == 8'd6, "R8 parity log index", 64'(par_log), 64'd6);
    chk(key_lo_q == 64'h3, "R7 read data with bad parity", key_lo_q, 64'h3);
    load(64'h1, 36'h0, 64'h0, 36'h0);
    run_cmd(RWR, 8'd7, 1'b1);
    run_cmd(RRD, 8'd7, 1'b0);
    chk(par_log == 8'd6, "R8 first log kept", 64'(par_log), 64'd6);
    wr(3'd5, 64'd1);
    chk(par_irq == 1'b0 && par_log == 8'd0, "R8 clear flag and log",
        64'({par_irq, par_log}), 64'd0);
    run_cmd(RRD, 8'd4, 1'b0);
    chk(par_irq == 1'b0, "R8 hardware parity read clean", 64'(par_irq), 64'd0);

    // R10 start ignored during bulk clear
    wr(3'd6, 64'd0);
    wr(3'd4, cw(CMP, 8'h21, 1'b0));
    chk(cmd_status == 1'b1, "R10 start ignored in clear", 64'(cmd_status), 64'd1);
    chk(lookup_en == 1'b0, "R10 lookup off", 64'(lookup_en), 64'd0);
    for (int t = 0; t < 100 && !init_done; t++) @(negedge clk);
    chk(cmd_addr == 8'd4, "R10 index kept", 64'(cmd_addr), 64'd4);
    load(64'h9999, 36'h3, 64'h0, 36'h0);
    run_cmd(CMP, 8'd11, 1'b0);
    chk(cmd_match && cmd_addr == 8'd0, "R9 second clear hits entry 0",
        64'({cmd_match, cmd_addr}), 64'h100);

    finish_up();
  end

endmodule